// File: doc/BRIEF.md
# Triplicated Serial Packet Sender with Per-Packet Flush

This block sends byte packets on a single serial line and hides single-copy state upsets from the line. Three identical copies of a serial packet sender get the same input stream and run in lockstep. A bitwise two-of-three majority picks each output bit. The voted result never goes back into the copies, so an upset copy is outvoted but keeps its bad state. To stop damage building up across packets, a flush controller holds all three copies in synchronous reset for a fixed number of cycles after every packet.

On the line, a packet is one low start bit, then every data byte with the least significant bit first, then one high stop bit. The line idles high. Bytes come in over a valid/ready port that has an end-of-packet flag. Each copy has a one-byte holding register, so a byte can queue behind the one being shifted. A fault port XORs a chosen mask into the state register of one copy, which lets verification hit any state bit. For each copy, a sticky flag shows whether that copy has disagreed with the voted line since the last flush.

Top module: `tmr_flush_tx`

## Requirements
- R1: After reset and between packets, `ser_out` is 1, `busy` is 0, `in_ready` is 1 and `disagree` is 0.
- R2: The cycle after the first byte of a packet is accepted, `ser_out` sends a 0 start bit. Next come the 8 bits of each byte, bit 0 first, one bit per cycle. After the final data bit comes a single 1 stop bit.
- R3: A byte accepted before the last data bit of the previous byte follows it with no gap and no extra start bit.
- R4: A byte is still missing, and not being accepted, in the cycle that sends the last data bit of a non-final byte. The stop bit then follows at once and the packet ends.
- R5: `busy` rises the cycle after the final byte is accepted (or in the stop-bit cycle after a missing byte). It stays high through the stop bit and then for exactly FLUSH_CYC (default 2) more cycles. `in_ready` is 0 while `busy` is 1. `ser_out` is 1 during the flush cycles.
- R6: `ser_out` is the bitwise two-of-three majority of the copies' line bits. An upset in any single copy at any point leaves the voted stream bit-exact.
- R7: With `flip_en` high, `flip_mask` is XORed into the state register of copy `flip_lane` (0..2) at that clock edge. `flip_lane` = 3 touches no copy. Mask bit 15 is the data bit that copy sends in the following cycle. Mask bit 24 is the upper bit of its phase code, where phase 0 = idle and 2 = data.
- R8: `disagree[i]` rises the cycle after copy i's line bit differs from `ser_out`. It stays high until the flush, and it reads 0 once `busy` falls.
- R9: The flush resets all three copies. A copy left upset at the end of one packet therefore cannot combine with an upset in another copy during the next packet.
- R10: During flush cycles, reset wins over fault injection. A flip applied in the last flush cycle leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Offered byte ends the packet |
| in_ready | output | 1 | Byte taken at the edge when valid and ready are both high |
| flip_en | input | 1 | Apply fault mask this edge |
| flip_lane | input | 2 | Copy to upset (3 = none) |
| flip_mask | input | 25 | Bits of copy state to invert |
| ser_out | output | 1 | Voted serial line |
| busy | output | 1 | Packet closing or flush in progress |
| disagree | output | 3 | Sticky per-copy mismatch against the voted line |

## Verification
Two things can land in the same cycle: an upset in one copy and the flush that clears it. The bench forces the overlap by firing the fault port in the last flush cycle. It then watches `disagree` after the flush: any change in phase would make that copy send zeros against a high voted line. A second overlap is a byte arriving in the same cycle as the missing-byte decision. The bench meets it with gaps kept shorter than a byte and with a directed missing-byte case, and it judges each packet as a bit-exact frame built from the bytes sent. Random packets take one random upset each, with a random copy, mask and time. The other copies' flags must stay low.

// File: rtl/tmr_tx_pkg.sv
package tmr_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int N_COPY = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;

    // Per-copy state; field order fixes the fault-mask bit positions.
    typedef struct packed {
        phase_e              phase;     // [24:23]
        logic [BYTE_W-1:0]   shreg;     // [22:15]
        logic [CNT_W-1:0]    bitcnt;    // [14:12]
        logic [BYTE_W-1:0]   hold;      // [11:4]
        logic                hold_vld;  // [3]
        logic                hold_last; // [2]
        logic                cur_last;  // [1]
        logic                closed;    // [0]
    } lane_st_t;

    localparam int ST_W = $bits(lane_st_t);

    // Signals each copy presents to the voter.
    typedef struct packed {
        logic line;
        logic ready;
        logic closed;
        logic done;
    } lane_obs_t;

    localparam int OBS_W = $bits(lane_obs_t);

    function automatic logic line_of(input lane_st_t s);
        case (s.phase)
            PH_START: return 1'b0;
            PH_DATA:  return s.shreg[0];
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_maj_vote.sv
module tmr_maj_vote #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    always_comb begin
        y = (a & b) | (a & c) | (b & c);
    end
endmodule

// File: rtl/tmr_tx_lane.sv
module tmr_tx_lane
    import tmr_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              inj_en,
    input  logic [ST_W-1:0]   inj_mask,
    output lane_obs_t         obs,
    output logic [1:0]        phase_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    lane_st_t st_q;
    lane_st_t st_d;
    logic     ready_l;
    logic     acc;

    always_comb begin
        ready_l = !st_q.closed && !st_q.hold_vld;
        acc     = in_valid && ready_l;
    end

    always_comb begin
        st_d = st_q;
        if (acc) begin
            st_d.closed = st_q.closed | in_last;
        end
        case (st_q.phase)
            PH_IDLE: begin
                if (acc) begin
                    st_d.phase    = PH_START;
                    st_d.shreg    = in_data;
                    st_d.cur_last = in_last;
                    st_d.bitcnt   = '0;
                end
            end
            PH_START: begin
                st_d.phase  = PH_DATA;
                st_d.bitcnt = '0;
                if (acc) begin
                    st_d.hold      = in_data;
                    st_d.hold_vld  = 1'b1;
                    st_d.hold_last = in_last;
                end
            end
            PH_DATA: begin
                st_d.shreg  = st_q.shreg >> 1;
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt != LAST_BIT) begin
                    if (acc) begin
                        st_d.hold      = in_data;
                        st_d.hold_vld  = 1'b1;
                        st_d.hold_last = in_last;
                    end
                end else if (st_q.cur_last) begin
                    st_d.phase = PH_STOP;
                end else if (st_q.hold_vld) begin
                    st_d.shreg    = st_q.hold;
                    st_d.cur_last = st_q.hold_last;
                    st_d.hold_vld = 1'b0;
                    st_d.bitcnt   = '0;
                end else if (acc) begin
                    st_d.shreg    = in_data;
                    st_d.cur_last = in_last;
                    st_d.bitcnt   = '0;
                end else begin
                    st_d.phase  = PH_STOP;
                    st_d.closed = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q <= '0;
        end else if (inj_en) begin
            st_q <= lane_st_t'(st_d ^ inj_mask);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        obs.line   = line_of(st_q);
        obs.ready  = ready_l;
        obs.closed = st_q.closed;
        obs.done   = (st_q.phase == PH_STOP);
        phase_o    = st_q.phase;
    end
endmodule

// File: rtl/tmr_flush_ctrl.sv
module tmr_flush_ctrl
    import tmr_tx_pkg::*;
#(
    parameter int FLUSH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_v,
    input  logic [N_COPY-1:0] lines,
    input  logic              line_v,
    output logic              flush,
    output logic [N_COPY-1:0] disagree
);
    localparam int FC_W = $clog2(FLUSH_CYC + 1);

    logic [FC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (done_v) begin
            cnt_q <= FC_W'(FLUSH_CYC);
        end
    end

    always_comb begin
        flush = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            disagree <= '0;
        end else begin
            disagree <= disagree | (lines ^ {N_COPY{line_v}});
        end
    end
endmodule

// File: rtl/tmr_flush_tx.sv
module tmr_flush_tx
    import tmr_tx_pkg::*;
#(
    parameter int FLUSH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              flip_en,
    input  logic [1:0]        flip_lane,
    input  logic [ST_W-1:0]   flip_mask,
    output logic              ser_out,
    output logic              busy,
    output logic [N_COPY-1:0] disagree
);
    lane_obs_t             obs [N_COPY];
    lane_obs_t             voted;
    logic [N_COPY-1:0]     lane_lines;
    logic [2*N_COPY-1:0]   lane_ph_flat;
    logic                  flush_w;

    for (genvar g = 0; g < N_COPY; g++) begin : g_copy
        logic inj_g;
        always_comb inj_g = flip_en && (flip_lane == 2'(g));

        tmr_tx_lane lane_i (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush_w),
            .in_valid (in_valid),
            .in_data  (in_data),
            .in_last  (in_last),
            .inj_en   (inj_g),
            .inj_mask (flip_mask),
            .obs      (obs[g]),
            .phase_o  (lane_ph_flat[2*g +: 2])
        );

        always_comb lane_lines[g] = obs[g].line;
    end

    tmr_maj_vote #(.W(OBS_W)) vote_i (
        .a (obs[0]),
        .b (obs[1]),
        .c (obs[2]),
        .y (voted)
    );

    tmr_flush_ctrl #(.FLUSH_CYC(FLUSH_CYC)) flush_i (
        .clk      (clk),
        .rst      (rst),
        .done_v   (voted.done),
        .lines    (lane_lines),
        .line_v   (voted.line),
        .flush    (flush_w),
        .disagree (disagree)
    );

    always_comb begin
        ser_out  = voted.line;
        in_ready = voted.ready && !flush_w;
        busy     = voted.closed || flush_w;
    end
endmodule

// File: rtl/tmr_flush_tx_chk.sv
module tmr_flush_tx_chk #(
    parameter int FLUSH_CYC = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       busy,
    input logic       ser_out,
    input logic [2:0] disagree,
    input logic       flush,
    input logic [5:0] lane_ph
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
        end else if (flush) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    a_r5_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    a_r5_line_high_flush: assert property (@(posedge clk) disable iff (rst)
        flush |-> ser_out);

    a_r5_flush_len: assert property (@(posedge clk) disable iff (rst)
        $fell(flush) |-> (run_len == FLUSH_CYC));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ((disagree & $past(disagree)) == $past(disagree)));

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        flush |=> (disagree == 3'b000));

    a_r10_reset_wins: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lane_ph == 6'b000000));
endmodule

bind tmr_flush_tx tmr_flush_tx_chk #(.FLUSH_CYC(FLUSH_CYC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .busy     (busy),
    .ser_out  (ser_out),
    .disagree (disagree),
    .flush    (flush_w),
    .lane_ph  (lane_ph_flat)
);

// File: tb/tmr_flush_tx_tb.sv
module tmr_flush_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MASK_W = 25;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic              flip_en = 1'b0;
    logic [1:0]        flip_lane = 2'd3;
    logic [MASK_W-1:0] flip_mask = '0;
    logic              ser_out;
    logic              busy;
    logic [2:0]        disagree;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    bit   exp_q[$];
    bit   mon_act = 1'b0;
    int   pkt_err = 0;
    int   pkt_exp_bit = 0;
    int   pkt_got_bit = 0;
    int   stop_seen = 0;
    int   rdy_viol = 0;
    logic [2:0] faulted = 3'b000;
    string pkt_tag = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_flush_tx dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .flip_en(flip_en),
        .flip_lane(flip_lane), .flip_mask(flip_mask), .ser_out(ser_out),
        .busy(busy), .disagree(disagree)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected frame: start 0, bytes LSB first, stop 1
    task automatic queue_frame(input logic [7:0] b [], input int n);
        exp_q.push_back(1'b0);
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++) exp_q.push_back(b[k][i]);
        exp_q.push_back(1'b1);
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (busy && in_ready) rdy_viol++;
            if (!mon_act && exp_q.size() > 0 && ser_out == 1'b0) begin
                mon_act = 1'b1;
                pkt_err = 0;
            end
            if (mon_act) begin
                bit e;
                e = exp_q.pop_front();
                if (ser_out !== e && pkt_err == 0) begin
                    pkt_exp_bit = int'(e);
                    pkt_got_bit = int'(ser_out);
                end
                if (ser_out !== e) pkt_err++;
                if (exp_q.size() == 0) begin
                    mon_act = 1'b0;
                    check(pkt_err == 0, pkt_tag, "frame bit mismatch (R6 vote)",
                          pkt_got_bit, pkt_exp_bit);
                    check(busy == 1'b1, "R5", "busy at stop bit", int'(busy), 1);
                    check((disagree & ~faulted) == 3'b000, "R8",
                          "flag on unfaulted copy", int'(disagree), 0);
                    stop_seen++;
                end
            end
        end
    end

    task automatic push_byte(input logic [7:0] d, input logic last);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic drop_valid();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (mon_act || exp_q.size() != 0 || busy);
        @(negedge clk);
    endtask

    task automatic inject(input int lane, input logic [MASK_W-1:0] m);
        flip_en = 1'b1; flip_lane = 2'(lane); flip_mask = m;
        @(negedge clk);
        flip_en = 1'b0; flip_lane = 2'd3; flip_mask = '0;
    endtask

    task automatic send_packet(input logic [7:0] b [], input int n,
                               input int max_gap);
        queue_frame(b, n);
        for (int k = 0; k < n; k++) begin
            push_byte(b[k], k == n - 1);
            if (max_gap > 0 && k < n - 1) begin
                int g;
                g = $urandom_range(max_gap, 0);
                if (g > 0) begin
                    @(negedge clk); in_valid = 1'b0;
                    repeat (g - 1) @(negedge clk);
                end
            end
        end
        drop_valid();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] pk [];
        int cnt;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ser_out == 1'b1, "R1", "idle line", int'(ser_out), 1);
        check(busy == 1'b0, "R1", "idle busy", int'(busy), 0);
        check(in_ready == 1'b1, "R1", "idle ready", int'(in_ready), 1);
        check(disagree == 3'b000, "R1", "idle flags", int'(disagree), 0);

        // R2 + R5: single final byte, busy lasts start+8+stop+2 cycles
        pkt_tag = "R2";
        pk = new[1]; pk[0] = 8'hB4;
        queue_frame(pk, 1);
        push_byte(8'hB4, 1'b1);
        cnt = 0;
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
        while (busy) begin cnt++; @(negedge clk); end
        check(cnt == 12, "R5", "busy cycle count", cnt, 12);
        check(in_ready == 1'b1, "R1", "ready after flush", int'(in_ready), 1);
        wait_idle();

        // R3: back-to-back multi-byte packet
        pkt_tag = "R3";
        pk = new[4]; pk[0] = 8'h01; pk[1] = 8'h80; pk[2] = 8'hFF; pk[3] = 8'h00;
        send_packet(pk, 4, 0);
        wait_idle();

        // R4: missing byte ends packet after first byte
        pkt_tag = "R4";
        pk = new[1]; pk[0] = 8'hA5;
        queue_frame(pk, 1);
        push_byte(8'hA5, 1'b0);
        drop_valid();
        wait_idle();
        check(in_ready == 1'b1 && busy == 1'b0, "R4", "idle after short packet",
              int'(in_ready), 1);

        // R7 + R8: flip data bit in copy 1, flag sticky, cleared by flush
        pkt_tag = "R7";
        faulted = 3'b010;
        pk = new[2]; pk[0] = 8'h3C; pk[1] = 8'hC3;
        queue_frame(pk, 2);
        fork
            begin
                push_byte(8'h3C, 1'b0);
                push_byte(8'hC3, 1'b1);
                drop_valid();
            end
            begin
                repeat (4) @(negedge clk);
                inject(1, 25'(1) << 15);
                repeat (7) @(negedge clk);
                check(disagree == 3'b010, "R8", "sticky flag copy 1",
                      int'(disagree), 2);
            end
        join
        wait_idle();
        check(disagree == 3'b000, "R8", "flag cleared by flush", int'(disagree), 0);

        // R7: lane select 3 touches nothing
        pkt_tag = "R7";
        faulted = 3'b000;
        pk = new[1]; pk[0] = 8'h5A;
        queue_frame(pk, 1);
        fork
            begin push_byte(8'h5A, 1'b1); drop_valid(); end
            begin repeat (4) @(negedge clk); inject(3, 25'(1) << 15); end
        join
        wait_idle();
        check(disagree == 3'b000, "R7", "lane 3 ignored", int'(disagree), 0);

        // R9: copy 0 left broken in packet A, copy 1 upset in packet B
        pkt_tag = "R9";
        faulted = 3'b001;
        pk = new[2]; pk[0] = 8'h96; pk[1] = 8'h69;
        queue_frame(pk, 2);
        fork
            begin push_byte(8'h96, 1'b0); push_byte(8'h69, 1'b1); drop_valid(); end
            begin repeat (5) @(negedge clk); inject(0, 25'h180_0000 | 25'h1); end
        join
        wait_idle();
        faulted = 3'b010;
        pk = new[2]; pk[0] = 8'hE1; pk[1] = 8'h1E;
        queue_frame(pk, 2);
        fork
            begin push_byte(8'hE1, 1'b0); push_byte(8'h1E, 1'b1); drop_valid(); end
            begin repeat (6) @(negedge clk); inject(1, 25'h7FFF); end
        join
        wait_idle();

        // R10: injection in last flush cycle is overridden by reset
        pkt_tag = "R10";
        faulted = 3'b000;
        pk = new[1]; pk[0] = 8'h77;
        begin
            int s0;
            s0 = stop_seen;
            queue_frame(pk, 1);
            push_byte(8'h77, 1'b1);
            drop_valid();
            wait (stop_seen == s0 + 1);
            @(negedge clk);
            @(negedge clk);
            inject(2, 25'(1) << 24);
            repeat (4) @(negedge clk);
            check(disagree == 3'b000, "R10", "flip during flush ignored",
                  int'(disagree), 0);
            check(ser_out == 1'b1 && busy == 1'b0, "R10", "line idle after flush",
                  int'(ser_out), 1);
        end
        wait_idle();

        // R6: random packets, one random upset each
        pkt_tag = "R6";
        for (int p = 0; p < 40; p++) begin
            int n, lane, dly;
            logic [MASK_W-1:0] m;
            n = $urandom_range(6, 1);
            pk = new[n];
            foreach (pk[i]) pk[i] = 8'($urandom);
            lane = $urandom_range(2, 0);
            dly = $urandom_range(n * 8, 1);
            m = MASK_W'($urandom);
            if (m == '0) m = 25'h1;
            faulted = 3'b000;
            faulted[lane] = 1'b1;
            fork
                send_packet(pk, n, 3);
                begin repeat (dly) @(negedge clk); inject(lane, m); end
            join
            wait_idle();
        end

        check(rdy_viol == 0, "R5", "ready while busy", rdy_viol, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule